// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: an address-latch strobe (active high) that tells an external latch when to capture the low address byte, and a code-read strobe (active low) that enables external program memory onto the bus. All timing derives from a machine cycle of twelve oscillator clocks. A free-running phase counter marks the position within that cycle, and the current phase is published to the core on `phase_o`. Only rising clock edges are used, so the duty cycle of the oscillator input does not matter.

Once per machine cycle, at its first clock, the block samples four request lines from the core. They say whether code is being fetched from external memory, whether the cycle performs an external data access, whether the cycle reads a code table, and whether the address-latch strobe should be kept quiet. In a plain cycle the latch strobe pulses twice, giving a constant rate of one sixth of the oscillator frequency. The code-read strobe is asserted twice per cycle during external execution. During an external data access, the first latch pulse and both code-read activations are left out. The quiet control silences the latch strobe only when nothing needs it. It has no effect during external execution, during an external data access or during a code-table read.

Top module: `busstb_gen`

## Requirements
- R1: While `rst_i` is high, the outputs become `addr_latch_o`=0, `code_rd_n_o`=1 and `phase_o`=0 at the next clock edge. After `rst_i` falls, the first clock edge starts a machine cycle with `phase_o`=0.
- R2: `phase_o` advances by one on each clock edge, from 0 to 11, and then wraps to 0. It gives the cycle position to which the current strobe values belong.
- R3: In a cycle with `ext_data_i`=0 and `latch_quiet_i`=0, `addr_latch_o` is 1 exactly at phases 0, 1, 6 and 7. This makes two pulses of two clocks each per cycle.
- R4: In a cycle with `ext_data_i`=1, the pulse at phases 0 and 1 is left out, and the pulse at phases 6 and 7 is kept.
- R5: In a cycle with `ext_code_i`=1 and `ext_data_i`=0, `code_rd_n_o` is 0 exactly at phases 3, 4, 5, 9, 10 and 11.
- R6: In a cycle with `ext_data_i`=1, `code_rd_n_o` stays 1 for the whole cycle, even when `ext_code_i`=1.
- R7: In a cycle with `ext_code_i`=0, `code_rd_n_o` stays 1 for the whole cycle.
- R8: In a cycle with `latch_quiet_i`=1 and `ext_code_i`, `ext_data_i` and `code_tab_i` all 0, `addr_latch_o` stays 0 for the whole cycle.
- R9: `latch_quiet_i`=1 has no effect when `ext_code_i`=1; the pulses of R3 or R4 appear as usual.
- R10: With `latch_quiet_i`=1, a cycle with `code_tab_i`=1 still gives both pulses, and a cycle with `ext_data_i`=1 still gives the pulse at phases 6 and 7.
- R11: The request inputs are sampled only at the clock edge that produces `phase_o`=0. A change at any other edge has no effect until the next cycle.
- R12: `addr_latch_o`=1 and `code_rd_n_o`=0 never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; rising edge only |
| rst_i | input | 1 | Synchronous reset, active high |
| ext_code_i | input | 1 | Code for this cycle is fetched from external memory |
| ext_data_i | input | 1 | This cycle performs an external data access |
| code_tab_i | input | 1 | This cycle reads a code table |
| latch_quiet_i | input | 1 | Request to silence the address-latch strobe |
| addr_latch_o | output | 1 | Address-latch strobe, active high |
| code_rd_n_o | output | 1 | External code-read strobe, active low |
| phase_o | output | 4 | Position within the machine cycle (0 to 11) |

## Verification
The assertions assume that `rst_i` is high from time zero until the first clock edges. They also assume that the clock runs without gaps, so that phase stepping can be checked from one edge to the next. They make no assumption about the request inputs, because the strobe windows, the pulse width and the exclusion between the two strobes must hold for any request pattern. The stimulus changes requests only on falling edges. It normally applies them just before the edge that starts a cycle, and in the R11 cases it deliberately changes them in the middle of a cycle.

// File: rtl/busstb_pkg.sv
package busstb_pkg;
    typedef struct packed {
        logic ext_code;
        logic ext_data;
        logic code_tab;
        logic quiet;
    } cyc_req_t;
endpackage

// File: rtl/busstb_phase.sv
module busstb_phase #(
    parameter int CYC_CLKS = 12,
    localparam int PW = $clog2(CYC_CLKS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [PW-1:0] phase_o,
    output logic          first_o
);
    localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign phase_o = cnt_q;
    assign first_o = (cnt_q == '0);
endmodule

// File: rtl/busstb_slot_dec.sv
module busstb_slot_dec #(
    parameter int CYC_CLKS = 12,
    parameter int LATCH_W  = 2,
    parameter int READ_W   = 3,
    localparam int PW = $clog2(CYC_CLKS)
) (
    input  logic [PW-1:0] phase_i,
    output logic [1:0]    latch_win_o,
    output logic [1:0]    read_win_o
);
    localparam int HALF     = CYC_CLKS / 2;
    localparam int READ_OFS = LATCH_W + 1;

    // Two identical halves per machine cycle, each with one latch slot
    // followed by one read slot.
    for (genvar g = 0; g < 2; g++) begin : g_half
        localparam int BASE = g * HALF;
        assign latch_win_o[g] = (int'(phase_i) >= BASE) &&
                                (int'(phase_i) <  BASE + LATCH_W);
        assign read_win_o[g]  = (int'(phase_i) >= BASE + READ_OFS) &&
                                (int'(phase_i) <  BASE + READ_OFS + READ_W);
    end
endmodule

// File: rtl/busstb_policy.sv
module busstb_policy
    import busstb_pkg::*;
(
    input  cyc_req_t   req_i,
    input  logic [1:0] latch_win_i,
    input  logic [1:0] read_win_i,
    output logic       latch_o,
    output logic       read_act_o
);
    logic latch_ok;

    always_comb begin
        // Quiet request only wins when no bus activity needs the latch.
        latch_ok   = !req_i.quiet || req_i.ext_code || req_i.ext_data ||
                     req_i.code_tab;
        // A data access drops the first latch slot and both read slots.
        latch_o    = latch_ok &&
                     ((latch_win_i[0] && !req_i.ext_data) || latch_win_i[1]);
        read_act_o = req_i.ext_code && !req_i.ext_data && (|read_win_i);
    end
endmodule

// File: rtl/busstb_gen.sv
module busstb_gen
    import busstb_pkg::*;
#(
    parameter int CYC_CLKS = 12,
    parameter int LATCH_W  = 2,
    parameter int READ_W   = 3,
    localparam int PW = $clog2(CYC_CLKS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ext_code_i,
    input  logic          ext_data_i,
    input  logic          code_tab_i,
    input  logic          latch_quiet_i,
    output logic          addr_latch_o,
    output logic          code_rd_n_o,
    output logic [PW-1:0] phase_o
);
    typedef struct packed {
        cyc_req_t      req;
        logic          latch;
        logic          rd_n;
        logic [PW-1:0] ph;
    } st_t;

    localparam st_t ST_RST = '{req: '0, latch: 1'b0, rd_n: 1'b1, ph: '0};

    st_t           st_d, st_q;
    logic [PW-1:0] cnt;
    logic          first;
    logic [1:0]    latch_win, read_win;
    logic          latch_v, read_act;
    cyc_req_t      req_in, req_now;

    busstb_phase #(.CYC_CLKS(CYC_CLKS)) u_phase (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .phase_o (cnt),
        .first_o (first)
    );

    busstb_slot_dec #(
        .CYC_CLKS (CYC_CLKS),
        .LATCH_W  (LATCH_W),
        .READ_W   (READ_W)
    ) u_dec (
        .phase_i     (cnt),
        .latch_win_o (latch_win),
        .read_win_o  (read_win)
    );

    assign req_in  = '{ext_code: ext_code_i, ext_data: ext_data_i,
                       code_tab: code_tab_i, quiet: latch_quiet_i};
    // Requests are taken at the cycle start and held for the whole cycle.
    assign req_now = first ? req_in : st_q.req;

    busstb_policy u_pol (
        .req_i       (req_now),
        .latch_win_i (latch_win),
        .read_win_i  (read_win),
        .latch_o     (latch_v),
        .read_act_o  (read_act)
    );

    always_comb begin
        st_d       = st_q;
        st_d.req   = req_now;
        st_d.latch = latch_v;
        st_d.rd_n  = !read_act;
        st_d.ph    = cnt;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_RST;
        else       st_q <= st_d;
    end

    assign addr_latch_o = st_q.latch;
    assign code_rd_n_o  = st_q.rd_n;
    assign phase_o      = st_q.ph;
endmodule

// File: rtl/busstb_chk.sv
module busstb_chk #(
    parameter int CYC_CLKS = 12,
    parameter int LATCH_W  = 2,
    parameter int READ_W   = 3,
    localparam int PW = $clog2(CYC_CLKS)
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          addr_latch_o,
    input logic          code_rd_n_o,
    input logic [PW-1:0] phase_o
);
    localparam int HALF = CYC_CLKS / 2;
    localparam int ROFS = LATCH_W + 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);

    p_reset_idle_r1: assert property (@(posedge clk_i)
        rst_i |=> (!addr_latch_o && code_rd_n_o && phase_o == '0));

    p_phase_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && phase_o != LAST) |=> phase_o == $past(phase_o) + PW'(1));

    p_phase_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && phase_o == LAST) |=> phase_o == '0);

    p_latch_window_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        addr_latch_o |-> (int'(phase_o) % HALF) < LATCH_W);

    p_latch_width_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(addr_latch_o) |=> addr_latch_o);

    p_read_window_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !code_rd_n_o |-> ((int'(phase_o) % HALF) >= ROFS &&
                          (int'(phase_o) % HALF) < ROFS + READ_W));

    p_no_overlap_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        addr_latch_o |-> code_rd_n_o);
endmodule

bind busstb_gen busstb_chk #(
    .CYC_CLKS (CYC_CLKS),
    .LATCH_W  (LATCH_W),
    .READ_W   (READ_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .addr_latch_o (addr_latch_o),
    .code_rd_n_o  (code_rd_n_o),
    .phase_o      (phase_o)
);

// File: tb/busstb_gen_tb.sv
`timescale 1ns/1ps
module busstb_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_code = 1'b0, ext_data = 1'b0, code_tab = 1'b0, quiet = 1'b0;
    logic       latch, rd_n;
    logic [3:0] phase;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  latch;
        logic  rd_n;
        int    ph;
        string tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    busstb_gen u_dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .ext_code_i    (ext_code),
        .ext_data_i    (ext_data),
        .code_tab_i    (code_tab),
        .latch_quiet_i (quiet),
        .addr_latch_o  (latch),
        .code_rd_n_o   (rd_n),
        .phase_o       (phase)
    );

    function automatic logic m_latch(int p, logic xc, logic xd, logic ct, logic qt);
        logic first_slot  = (p == 0 || p == 1);
        logic second_slot = (p == 6 || p == 7);
        logic ok          = !qt || xc || xd || ct;
        return ok && ((first_slot && !xd) || second_slot);
    endfunction

    function automatic logic m_rd_n(int p, logic xc, logic xd);
        logic win = (p >= 3 && p <= 5) || (p >= 9 && p <= 11);
        return !(xc && !xd && win);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of requests and queue its twelve expected slots.
    task automatic run_cycle(logic xc, logic xd, logic ct, logic qt, bit chg, string tag);
        ext_code = xc; ext_data = xd; code_tab = ct; quiet = qt;
        for (int p = 0; p < 12; p++) begin
            exp_t e;
            e.latch = m_latch(p, xc, xd, ct, qt);
            e.rd_n  = m_rd_n(p, xc, xd);
            e.ph    = p;
            e.tag   = tag;
            q.push_back(e);
        end
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (chg && i == 5) begin
                ext_code = ~xc; ext_data = ~xd; code_tab = ~ct; quiet = ~qt;
            end
        end
    endtask

    // Monitor: compare each produced slot with the queued expectation.
    always @(posedge clk) begin
        exp_t e;
        #3;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "addr_latch", int'(latch), int'(e.latch));
            chk(e.tag, "code_rd_n", int'(rd_n), int'(e.rd_n));
            chk("R2", "phase", int'(phase), e.ph);
            chk("R12", "strobe overlap", int'(latch && !rd_n), 0);
        end
    end

    initial begin
        #100us;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) begin
            @(posedge clk); #3;
            chk("R1", "reset latch", int'(latch), 0);
            chk("R1", "reset rd_n", int'(rd_n), 1);
            chk("R1", "reset phase", int'(phase), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        run_cycle(0, 0, 0, 0, 0, "R3 R7 R1");
        run_cycle(1, 0, 0, 0, 0, "R5 R3");
        run_cycle(1, 1, 0, 0, 0, "R4 R6");
        run_cycle(0, 1, 0, 0, 0, "R4 R7");
        run_cycle(0, 0, 0, 1, 0, "R8");
        run_cycle(1, 0, 0, 1, 0, "R9");
        run_cycle(1, 1, 0, 1, 0, "R9 R6");
        run_cycle(0, 0, 1, 1, 0, "R10");
        run_cycle(0, 1, 0, 1, 0, "R10");
        run_cycle(1, 0, 0, 0, 1, "R11");
        run_cycle(0, 0, 0, 1, 1, "R11");
        run_cycle(0, 1, 0, 0, 1, "R11");
        run_cycle(1, 0, 1, 0, 0, "R5 R3");

        // Reset in the middle of a cycle, then confirm the restart at phase 0.
        ext_code = 1'b1; ext_data = 1'b0; code_tab = 1'b0; quiet = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid reset latch", int'(latch), 0);
        chk("R1", "mid reset rd_n", int'(rd_n), 1);
        chk("R1", "mid reset phase", int'(phase), 0);
        rst = 1'b0;
        run_cycle(1, 0, 0, 0, 0, "R1 R5");
        run_cycle(0, 0, 0, 0, 0, "R3");

        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule